// File: doc/BRIEF.md
# Long-Word Compare Flag Unit

This block performs the flag half of a signed long-word comparison. It takes the destination from an accumulator that carries a 4-bit extension nibble above a 32-bit body. The source is either a 32-bit register value or a 16-bit immediate. Both 32-bit operands are widened by sign extension to the full accumulator width, and the source is subtracted from the destination. The difference goes only to flag logic and is never stored anywhere. The resulting condition codes are merged into the low byte of the status register.

An execution pipeline drives the operands and the low status byte every cycle and pulses the execute strobe in the cycle the compare retires. The updated byte appears on the output one clock later. It stays unchanged until the next strobe or a synchronous reset. The saturation mode bit is wired in so the block sits on the same datapath as the arithmetic units, but it has no influence on the compare.

Top module: `lcmp_flag_unit`

## Requirements
- R1: A synchronous reset (`rst` high at a rising edge) sets `sr_out` to 8'h00, even if `exec_en` is high in the same cycle.
- R2: When `exec_en` is low and `rst` is low at a rising edge, `sr_out` keeps its previous value whatever the other inputs do.
- R3: When `exec_en` is high at a rising edge, `sr_out[7:6]` takes the value of `sr_in[7:6]`, and `sr_out[5:0]` takes the newly computed flags. The result is visible after that edge.
- R4: When `imm_sel` is 1, the source is `src_imm` sign-extended to 32 bits. When `imm_sel` is 0, the source is `src_reg`.
- R5: Bit 3 (N) equals bit 31 of the difference `sext36(dst_acc[31:0]) - sext36(src)`.
- R6: Bit 2 (Z) is 1 exactly when bits 31..0 of the difference are all zero.
- R7: Bit 0 (C) is 1 exactly when the subtraction borrows out of bit 31, that is, when `dst_acc[31:0] < src` compared as unsigned numbers.
- R8: Bit 1 (V) is 1 exactly when the signed 32-bit subtraction overflows, that is, when the true difference lies outside [-2^31, 2^31-1].
- R9: Bit 5 (E) is 1 exactly when bits 35..31 of the 36-bit difference are not all equal.
- R10: Bit 4 (U) is 1 exactly when bits 31 and 30 of the difference are equal.
- R11: Neither the extension nibble `dst_acc[35:32]` nor `sat_mode` has any effect on `sr_out`.
- R12: With destination 36'h0_0020_0000, source 32'h0024_0000 and `sr_in` 8'h00, one strobe gives `sr_out` = 8'h19 (C, N and U set).

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous reset, active high |
| exec_en | input | 1 | Execute strobe; the flag byte is written when it is high |
| imm_sel | input | 1 | Source select: 1 selects the immediate, 0 selects the register |
| dst_acc | input | 36 | Destination accumulator: extension nibble in the upper 4 bits, body in the lower 32 |
| src_reg | input | 32 | Register source operand |
| src_imm | input | 16 | Immediate source operand |
| sat_mode | input | 1 | Saturation mode bit; has no effect on this operation |
| sr_in | input | 8 | Current low byte of the status register |
| sr_out | output | 8 | Registered low status byte after the compare |

## Verification
The bound properties assume that `exec_en` and every operand input are stable and known at each rising edge. They also assume that reset is held for at least one edge before the first strobe, so that every `$past` look-back refers to a cycle with defined inputs. The bench meets these assumptions by changing all inputs only on falling edges, holding reset over several edges at the start, and leaving the strobe low throughout reset. It then sweeps every pairing of a set of boundary operands, with the immediate path exercised separately. Each flag is predicted from 64-bit signed arithmetic computed in the bench.

// File: rtl/lcmp_pkg.sv
package lcmp_pkg;

   // Bit positions of the condition codes inside the low status byte.
   localparam int CC_C  = 0;
   localparam int CC_V  = 1;
   localparam int CC_Z  = 2;
   localparam int CC_N  = 3;
   localparam int CC_U  = 4;
   localparam int CC_E  = 5;
   localparam int CC_L  = 6;
   localparam int CC_SZ = 7;

   localparam int SR_BYTE_W = 8;

   // Bits that the compare passes through from the incoming status byte.
   localparam logic [SR_BYTE_W-1:0] SR_KEEP_MASK = 8'hC0;

   typedef struct packed {
      logic ext_used;
      logic unnorm;
      logic neg;
      logic zero;
      logic ovf;
      logic borrow;
   } cc_flags_t;

   // Place the flags at their positions; bits that are kept read as zero here.
   function automatic logic [SR_BYTE_W-1:0] flags_to_byte(input cc_flags_t f);
      logic [SR_BYTE_W-1:0] b;
      b        = '0;
      b[CC_C]  = f.borrow;
      b[CC_V]  = f.ovf;
      b[CC_Z]  = f.zero;
      b[CC_N]  = f.neg;
      b[CC_U]  = f.unnorm;
      b[CC_E]  = f.ext_used;
      return b;
   endfunction

endpackage

// File: rtl/lcmp_src_sel.sv
// Chooses the 32-bit source: register value or sign-extended immediate.
module lcmp_src_sel #(
   parameter int DATA_W  = 32,
   parameter int IMM_W   = 16,
   parameter bit HAS_IMM = 1'b1
) (
   input  logic              imm_sel,
   input  logic [DATA_W-1:0] src_reg,
   input  logic [IMM_W-1:0]  src_imm,
   output logic [DATA_W-1:0] src_word
);
   localparam int PAD_W = DATA_W - IMM_W;

   initial begin
      if (IMM_W < 1 || PAD_W < 1)
         $error("lcmp_src_sel: immediate must be narrower than the data word");
   end

   generate
      if (HAS_IMM) begin : g_imm
         logic [DATA_W-1:0] imm_wide;
         always_comb imm_wide = {{PAD_W{src_imm[IMM_W-1]}}, src_imm};
         always_comb src_word = imm_sel ? imm_wide : src_reg;
      end else begin : g_reg_only
         logic unused_imm;
         always_comb unused_imm = imm_sel ^ (^src_imm);
         always_comb src_word   = src_reg;
      end
   endgenerate

endmodule

// File: rtl/lcmp_sub_ext.sv
// Sign-extends both operands to the accumulator width and subtracts.
// The borrow out of the top data bit comes from a separate unsigned path.
module lcmp_sub_ext #(
   parameter int DATA_W = 32,
   parameter int EXT_W  = 4
) (
   input  logic [DATA_W-1:0]       dst_word,
   input  logic [DATA_W-1:0]       src_word,
   output logic [EXT_W+DATA_W-1:0] diff,
   output logic                    borrow
);
   localparam int ACC_W = EXT_W + DATA_W;

   logic [ACC_W-1:0]  dst_x;
   logic [ACC_W-1:0]  src_x;
   logic [DATA_W:0]   low_sub;

   always_comb begin
      dst_x   = {{EXT_W{dst_word[DATA_W-1]}}, dst_word};
      src_x   = {{EXT_W{src_word[DATA_W-1]}}, src_word};
      diff    = dst_x - src_x;
      low_sub = {1'b0, dst_word} - {1'b0, src_word};
      borrow  = low_sub[DATA_W];
   end

endmodule

// File: rtl/lcmp_flag_gen.sv
// Derives the condition codes from the extended difference.
module lcmp_flag_gen
   import lcmp_pkg::*;
#(
   parameter int DATA_W = 32,
   parameter int EXT_W  = 4
) (
   input  logic [EXT_W+DATA_W-1:0] diff,
   input  logic                    borrow,
   input  logic                    dst_sign,
   input  logic                    src_sign,
   output cc_flags_t               flags
);
   localparam int ACC_W = EXT_W + DATA_W;
   localparam int TOP   = DATA_W - 1;

   logic [EXT_W:0] guard;

   always_comb begin
      guard           = diff[ACC_W-1:TOP];
      flags.borrow    = borrow;
      flags.neg       = diff[TOP];
      flags.zero      = ~|diff[TOP:0];
      flags.ovf       = (dst_sign ^ src_sign) & (diff[TOP] ^ dst_sign);
      flags.ext_used  = ~((&guard) | (~|guard));
      flags.unnorm    = ~(diff[TOP] ^ diff[TOP-1]);
   end

endmodule

// File: rtl/lcmp_flag_unit.sv
// Top: long-word compare that writes only the condition codes.
module lcmp_flag_unit
   import lcmp_pkg::*;
#(
   parameter int DATA_W  = 32,
   parameter int EXT_W   = 4,
   parameter int IMM_W   = 16,
   parameter bit HAS_IMM = 1'b1
) (
   input  logic                    clk,
   input  logic                    rst,
   input  logic                    exec_en,
   input  logic                    imm_sel,
   input  logic [EXT_W+DATA_W-1:0] dst_acc,
   input  logic [DATA_W-1:0]       src_reg,
   input  logic [IMM_W-1:0]        src_imm,
   input  logic                    sat_mode,
   input  logic [SR_BYTE_W-1:0]    sr_in,
   output logic [SR_BYTE_W-1:0]    sr_out
);
   localparam int ACC_W = EXT_W + DATA_W;

   initial begin
      if (DATA_W < 2)  $error("lcmp_flag_unit: DATA_W must be at least 2");
      if (EXT_W < 1)   $error("lcmp_flag_unit: EXT_W must be at least 1");
      if (IMM_W >= DATA_W) $error("lcmp_flag_unit: IMM_W must be below DATA_W");
   end

   logic [DATA_W-1:0]    src_word;
   logic [DATA_W-1:0]    dst_word;
   logic [ACC_W-1:0]     diff;
   logic                 borrow;
   cc_flags_t            flags;
   logic [SR_BYTE_W-1:0] flag_byte;
   logic [SR_BYTE_W-1:0] next_byte;
   logic [SR_BYTE_W-1:0] sr_q;

   // Only the body of the accumulator takes part; the nibble is re-derived.
   always_comb dst_word = dst_acc[DATA_W-1:0];

   lcmp_src_sel #(
      .DATA_W (DATA_W),
      .IMM_W  (IMM_W),
      .HAS_IMM(HAS_IMM)
   ) u_src (
      .imm_sel (imm_sel),
      .src_reg (src_reg),
      .src_imm (src_imm),
      .src_word(src_word)
   );

   lcmp_sub_ext #(
      .DATA_W(DATA_W),
      .EXT_W (EXT_W)
   ) u_sub (
      .dst_word(dst_word),
      .src_word(src_word),
      .diff    (diff),
      .borrow  (borrow)
   );

   lcmp_flag_gen #(
      .DATA_W(DATA_W),
      .EXT_W (EXT_W)
   ) u_flags (
      .diff    (diff),
      .borrow  (borrow),
      .dst_sign(dst_word[DATA_W-1]),
      .src_sign(src_word[DATA_W-1]),
      .flags   (flags)
   );

   always_comb flag_byte = flags_to_byte(flags);

   // Per-bit merge: kept bits pass from sr_in, the rest take the new flags.
   generate
      for (genvar gi = 0; gi < SR_BYTE_W; gi++) begin : g_merge
         if (SR_KEEP_MASK[gi]) begin : g_keep
            always_comb next_byte[gi] = sr_in[gi];
         end else begin : g_new
            logic unused_in;
            always_comb unused_in     = sr_in[gi];
            always_comb next_byte[gi] = flag_byte[gi];
         end
      end
   endgenerate

   always_ff @(posedge clk) begin
      if (rst)
         sr_q <= '0;
      else if (exec_en)
         sr_q <= next_byte;
   end

   always_comb sr_out = sr_q;

endmodule

// File: rtl/lcmp_flag_chk.sv
// Property checker attached to every instance of the top module.
module lcmp_flag_chk #(
   parameter int DATA_W = 32,
   parameter int EXT_W  = 4,
   parameter int IMM_W  = 16
) (
   input logic                    clk,
   input logic                    rst,
   input logic                    exec_en,
   input logic                    imm_sel,
   input logic [EXT_W+DATA_W-1:0] dst_acc,
   input logic [DATA_W-1:0]       src_reg,
   input logic [IMM_W-1:0]        src_imm,
   input logic                    sat_mode,
   input logic [7:0]              sr_in,
   input logic [7:0]              sr_out
);

   // R1: reset wins over everything.
   a_r1_reset_clears: assert property (@(posedge clk)
      rst |=> sr_out == 8'h00);

   // R2: no strobe, no change.
   a_r2_hold_idle: assert property (@(posedge clk) disable iff (rst)
      !exec_en |=> $stable(sr_out));

   // R3: upper bits pass through from the incoming byte.
   a_r3_keep_upper: assert property (@(posedge clk) disable iff (rst)
      exec_en |=> sr_out[7:6] == $past(sr_in[7:6]));

   // R6 and R7: equal register operands give zero without borrow or overflow.
   a_r6_equal_operands: assert property (@(posedge clk) disable iff (rst)
      (exec_en && !imm_sel && dst_acc[DATA_W-1:0] == src_reg)
      |=> (sr_out[2] && !sr_out[0] && !sr_out[1] && !sr_out[3]));

   // R9: with sign-extended operands the extension is in use exactly on overflow.
   a_r9_ext_tracks_ovf: assert property (@(posedge clk) disable iff (rst)
      exec_en |=> sr_out[5] == sr_out[1]);

   // R11: two strobes on equal body operands give the same byte, whatever the nibble or sat_mode.
   a_r11_ext_sat_ignored: assert property (@(posedge clk) disable iff (rst)
      (exec_en && $past(exec_en) && !$past(rst)
       && dst_acc[DATA_W-1:0] == $past(dst_acc[DATA_W-1:0])
       && src_reg == $past(src_reg) && src_imm == $past(src_imm)
       && imm_sel == $past(imm_sel) && sr_in == $past(sr_in)
       && (dst_acc[EXT_W+DATA_W-1:DATA_W] != $past(dst_acc[EXT_W+DATA_W-1:DATA_W])
           || sat_mode != $past(sat_mode)))
      |=> $stable(sr_out));

endmodule

bind lcmp_flag_unit lcmp_flag_chk #(
   .DATA_W(DATA_W),
   .EXT_W (EXT_W),
   .IMM_W (IMM_W)
) u_chk (
   .clk     (clk),
   .rst     (rst),
   .exec_en (exec_en),
   .imm_sel (imm_sel),
   .dst_acc (dst_acc),
   .src_reg (src_reg),
   .src_imm (src_imm),
   .sat_mode(sat_mode),
   .sr_in   (sr_in),
   .sr_out  (sr_out)
);

// File: tb/tb_lcmp_flag_unit.sv
module tb_lcmp_flag_unit;

   logic        clk = 1'b0;
   logic        rst = 1'b1;
   logic        exec_en = 1'b0;
   logic        imm_sel = 1'b0;
   logic [35:0] dst_acc = '0;
   logic [31:0] src_reg = '0;
   logic [15:0] src_imm = '0;
   logic        sat_mode = 1'b0;
   logic [7:0]  sr_in = '0;
   logic [7:0]  sr_out;

   int n_checks = 0;
   int n_fails  = 0;
   bit done     = 1'b0;

   always #5 clk = ~clk;

   lcmp_flag_unit dut (
      .clk(clk), .rst(rst), .exec_en(exec_en), .imm_sel(imm_sel),
      .dst_acc(dst_acc), .src_reg(src_reg), .src_imm(src_imm),
      .sat_mode(sat_mode), .sr_in(sr_in), .sr_out(sr_out)
   );

   function automatic logic [31:0] corner(input int k);
      case (k)
         0: return 32'h0000_0000;   1: return 32'h0000_0001;
         2: return 32'hFFFF_FFFF;   3: return 32'h7FFF_FFFF;
         4: return 32'h8000_0000;   5: return 32'h4000_0000;
         6: return 32'h3FFF_FFFF;   7: return 32'hC000_0000;
         8: return 32'h0020_0000;   9: return 32'h0024_0000;
         10: return 32'hBFFF_FFFF;  default: return 32'h8000_0001;
      endcase
   endfunction

   function automatic logic [15:0] imm_corner(input int k);
      case (k)
         0: return 16'h0000; 1: return 16'h0001; 2: return 16'hFFFF;
         3: return 16'h7FFF; 4: return 16'h8000; 5: return 16'h0024;
         6: return 16'hC000; default: return 16'h8001;
      endcase
   endfunction

   // Expected byte from 64-bit signed arithmetic.
   function automatic logic [7:0] model(input logic [31:0] d, input logic [31:0] s,
                                        input logic [7:0] sri);
      longint sd, ss, df;
      logic [63:0] w;
      logic [7:0]  r;
      sd = longint'($signed(d));
      ss = longint'($signed(s));
      df = sd - ss;
      w  = 64'(df);
      r  = '0;
      r[7:6] = sri[7:6];
      r[0] = (d < s);
      r[1] = (df > 64'sd2147483647) || (df < -64'sd2147483648);
      r[2] = (w[31:0] == 32'd0);
      r[3] = w[31];
      r[4] = (w[31] == w[30]);
      r[5] = !((w[35:31] == 5'b00000) || (w[35:31] == 5'b11111));
      return r;
   endfunction

   task automatic chk(input string tag, input logic [7:0] got, input logic [7:0] exp);
      n_checks++;
      if (got !== exp) begin
         n_fails++;
         $display("FAIL %s actual=%02h expected=%02h", tag, got, exp);
      end
   endtask

   task automatic chk_fields(input string ctx, input logic [7:0] got, input logic [7:0] exp);
      chk({"R7 C ", ctx},  {7'd0, got[0]}, {7'd0, exp[0]});
      chk({"R8 V ", ctx},  {7'd0, got[1]}, {7'd0, exp[1]});
      chk({"R6 Z ", ctx},  {7'd0, got[2]}, {7'd0, exp[2]});
      chk({"R5 N ", ctx},  {7'd0, got[3]}, {7'd0, exp[3]});
      chk({"R10 U ", ctx}, {7'd0, got[4]}, {7'd0, exp[4]});
      chk({"R9 E ", ctx},  {7'd0, got[5]}, {7'd0, exp[5]});
      chk({"R3 upper ", ctx}, {6'd0, got[7:6]}, {6'd0, exp[7:6]});
   endtask

   // Drive one strobe at a falling edge; the result is sampled at the next falling edge.
   task automatic run_op(input logic [35:0] d, input logic [31:0] s, input logic [15:0] im,
                         input logic isel, input logic [7:0] sri, input logic sat);
      @(negedge clk);
      dst_acc = d; src_reg = s; src_imm = im; imm_sel = isel;
      sr_in = sri; sat_mode = sat; exec_en = 1'b1;
      @(negedge clk);
      exec_en = 1'b0;
   endtask

   initial begin
      repeat (50000) @(posedge clk);
      if (!done) begin
         n_fails++;
         $display("FAIL R2 watchdog actual=timeout expected=completion");
         $display("  [TB] %0d tests run, %0d failed", n_checks, n_fails);
         $finish;
      end
   end

   initial begin
      logic [7:0] first;
      repeat (3) @(negedge clk);
      chk("R1 reset state", sr_out, 8'h00);
      rst = 1'b0;

      // R12: worked example.
      run_op(36'h0_0020_0000, 32'h0024_0000, 16'h0, 1'b0, 8'h00, 1'b0);
      chk("R12 example", sr_out, 8'h19);

      // Register-source sweep over every pair of corner values.
      for (int i = 0; i < 12; i++) begin
         for (int j = 0; j < 12; j++) begin
            logic [7:0]  sri;
            logic [31:0] d, s;
            d   = corner(i);
            s   = corner(j);
            sri = 8'(i * 37 + j * 11);
            run_op({4'(i ^ j), d}, s, 16'(j * 5), 1'b0, sri, 1'(j));
            chk_fields($sformatf("reg i=%0d j=%0d", i, j), sr_out, model(d, s, sri));
         end
      end

      // R4: immediate-source sweep.
      for (int i = 0; i < 12; i++) begin
         for (int k = 0; k < 8; k++) begin
            logic [31:0] d, s;
            logic [7:0]  sri;
            d   = corner(i);
            s   = {{16{imm_corner(k)[15]}}, imm_corner(k)};
            sri = 8'(k * 53 + i);
            run_op({4'(k), d}, ~s, imm_corner(k), 1'b1, sri, 1'(i));
            chk_fields($sformatf("R4 imm i=%0d k=%0d", i, k), sr_out, model(d, s, sri));
         end
      end

      // R11: same body, different nibble and saturation bit.
      run_op(36'h0_8000_0000, 32'h0000_0001, 16'h0, 1'b0, 8'h40, 1'b0);
      first = sr_out;
      chk("R11 base", first, model(32'h8000_0000, 32'h1, 8'h40));
      run_op(36'hA_8000_0000, 32'h0000_0001, 16'h0, 1'b0, 8'h40, 1'b1);
      chk("R11 nibble and sat_mode ignored", sr_out, first);

      // R2: inputs change without a strobe.
      run_op(36'h0_0000_0005, 32'h0000_0005, 16'h0, 1'b0, 8'h80, 1'b0);
      first = sr_out;
      for (int c = 0; c < 3; c++) begin
         @(negedge clk);
         dst_acc = 36'h3_1234_5678; src_reg = 32'(c * 99); sr_in = 8'hFF;
         imm_sel = 1'(c); src_imm = 16'hF00F;
         @(negedge clk);
         chk("R2 hold without strobe", sr_out, first);
      end

      // R1: reset while strobing.
      @(negedge clk);
      rst = 1'b1; exec_en = 1'b1; sr_in = 8'hFF; dst_acc = '0; src_reg = 32'h1; imm_sel = 1'b0;
      @(negedge clk);
      chk("R1 reset beats strobe", sr_out, 8'h00);
      rst = 1'b0; exec_en = 1'b0;

      done = 1'b1;
      $display("  [TB] %0d tests run, %0d failed", n_checks, n_fails);
      $finish;
   end

endmodule